// File: doc/BRIEF.md
# Timed Morse Letter Transmitter

This block sends one of eight letters, A through H, as Morse code on a single lamp output. A 3-bit selector picks the letter and a one-cycle start pulse launches the transmission. The lamp then shows each symbol of the letter in turn: a dot is a short on-pulse and a dash is a long on-pulse. A short dark gap separates the symbols.

All timing is built from one unit, half a second, that a divider derives from the system clock. The divider ratio is CLK_HZ / TICK_HZ, so a simulation can run with a ratio of a few cycles.

Inside, a control state machine coordinates three datapath pieces:
- a shift register that holds the letter's dot/dash bits;
- a counter that holds the number of symbols still to send;
- the unit divider.

Reset is asynchronous and active low.

Top module: `morse_tx`

## Requirements
- R1: `letter_i` selects the letter as follows: 0=A, 1=B, 2=C, 3=D, 4=E, 5=F, 6=G, 7=H. The symbols, first symbol first, are:
  - A: dot, dash
  - B: dash, dot, dot, dot
  - C: dash, dot, dash, dot
  - D: dash, dot, dot
  - E: dot
  - F: dot, dot, dash, dot
  - G: dash, dash, dot
  - H: dot, dot, dot, dot
- R2: One unit is U = CLK_HZ/TICK_HZ clock cycles. A dot holds `lamp_o` high for exactly U cycles. A dash holds it high for exactly 3U cycles.
- R3: Consecutive symbols are separated by exactly U cycles with `lamp_o` low. After the last symbol `lamp_o` stays low until a new start is accepted.
- R4: The letter is taken from `letter_i` in the cycle in which the start is accepted. Later changes of `letter_i` have no effect on the transmission in progress.
- R5: A `start_i` pulse that arrives while a transmission is in progress is ignored. The current letter continues unchanged, and no new transmission follows.
- R6: Driving `rst_ni` low forces `lamp_o` low at once, without waiting for a clock edge. After release the block is idle, and the next start sends a complete letter from its first symbol.
- R7: When idle, a start sampled at a rising edge makes `lamp_o` high from that edge on. A new start is accepted in the first idle cycle after a transmission ends.
- R8: While idle and with no start, `lamp_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled on the rising clock edge |
| letter_i | input | 3 | Letter select, 0=A to 7=H |
| lamp_o | output | 1 | Morse output, high while a symbol is shown |

## Verification
The assertions check, on every cycle, the state invariants:
- the symbol counter stays within range and is zero whenever the block is idle;
- a start from idle lights the lamp on the next cycle;
- every lamp rise loads a one-unit or three-unit duration;
- a start during a transmission leaves the symbol counter untouched.

The exact lamp waveform of each letter can only be shown by the bench scenarios. This covers the symbol order, the cycle counts of dots, dashes and gaps, and the silence after the last symbol. The same holds for the effect of changing the selector mid-letter, for the immediate effect of an asynchronous reset between clock edges, and for a restart in the first idle cycle.

// File: rtl/morse_pkg.sv
package morse_pkg;
  localparam int SYM_MAX = 4;
  localparam int LEN_W   = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_ON, ST_GAP} morse_st_e;

  typedef struct packed {
    logic [LEN_W-1:0]   len;
    logic [SYM_MAX-1:0] pat;  // bit0 first, 1 = dash
  } morse_code_t;

  function automatic morse_code_t letter_code(input logic [2:0] sel);
    morse_code_t c;
    case (sel)
      3'd0:    c = '{len: 3'd2, pat: 4'b0010};
      3'd1:    c = '{len: 3'd4, pat: 4'b0001};
      3'd2:    c = '{len: 3'd4, pat: 4'b0101};
      3'd3:    c = '{len: 3'd3, pat: 4'b0001};
      3'd4:    c = '{len: 3'd1, pat: 4'b0000};
      3'd5:    c = '{len: 3'd4, pat: 4'b0100};
      3'd6:    c = '{len: 3'd3, pat: 4'b0011};
      default: c = '{len: 3'd4, pat: 4'b0000};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/morse_tick.sv
module morse_tick #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!run_i)       cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/morse_shreg.sv
module morse_shreg #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [N-1:0] d_i,
  output logic         head_o
);
  logic [N-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (load_i)  q <= d_i;
    else if (shift_i) q <= {1'b0, q[N-1:1]};
  end

  assign head_o = q[0];
endmodule

// File: rtl/morse_len.sv
module morse_len #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         dec_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cnt_o,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= d_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == W'(1));
endmodule

// File: rtl/morse_fsm.sv
module morse_fsm
  import morse_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       first_dash_i,
  input  logic       head_i,
  input  logic       last_i,
  input  logic       tick_i,
  output logic       load_o,
  output logic       shift_o,
  output logic       dec_o,
  output logic       run_o,
  output logic       lamp_o,
  output morse_st_e  st_o,
  output logic [1:0] unit_o
);
  morse_st_e  st_q, st_d;
  logic [1:0] unit_q, unit_d;

  always_comb begin
    st_d    = st_q;
    unit_d  = unit_q;
    load_o  = 1'b0;
    shift_o = 1'b0;
    dec_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_i) begin
        load_o = 1'b1;
        st_d   = ST_ON;
        unit_d = first_dash_i ? 2'd3 : 2'd1;
      end
      ST_ON: if (tick_i) begin
        if (unit_q == 2'd1) begin
          shift_o = 1'b1;
          dec_o   = 1'b1;
          st_d    = last_i ? ST_IDLE : ST_GAP;
          unit_d  = 2'd0;
        end else begin
          unit_d = unit_q - 2'd1;
        end
      end
      ST_GAP: if (tick_i) begin
        st_d   = ST_ON;
        unit_d = head_i ? 2'd3 : 2'd1;  // head already shifted to next symbol
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      unit_q <= '0;
    end else begin
      st_q   <= st_d;
      unit_q <= unit_d;
    end
  end

  assign run_o  = (st_q != ST_IDLE);
  assign lamp_o = (st_q == ST_ON);
  assign st_o   = st_q;
  assign unit_o = unit_q;
endmodule

// File: rtl/morse_tx.sv
module morse_tx
  import morse_pkg::*;
#(
  parameter int CLK_HZ  = 50_000_000,
  parameter int TICK_HZ = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [2:0] letter_i,
  output logic       lamp_o
);
  localparam int DIV = (CLK_HZ / TICK_HZ > 0) ? CLK_HZ / TICK_HZ : 1;

  morse_code_t      code;
  logic             load, shift, dec, run, tick, head, last;
  logic [LEN_W-1:0] len_cnt;
  logic [1:0]       unit_cnt;
  morse_st_e        st;

  assign code = letter_code(letter_i);

  morse_tick #(.DIV(DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run), .tick_o(tick)
  );

  morse_shreg #(.N(SYM_MAX)) u_pat (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .shift_i(shift),
    .d_i(code.pat), .head_o(head)
  );

  morse_len #(.W(LEN_W)) u_len (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .dec_i(dec),
    .d_i(code.len), .cnt_o(len_cnt), .last_o(last)
  );

  morse_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .first_dash_i(code.pat[0]), .head_i(head), .last_i(last), .tick_i(tick),
    .load_o(load), .shift_o(shift), .dec_o(dec), .run_o(run),
    .lamp_o(lamp_o), .st_o(st), .unit_o(unit_cnt)
  );
endmodule

// File: rtl/morse_tx_chk.sv
module morse_tx_chk
  import morse_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             lamp_o,
  input morse_st_e        st,
  input logic [LEN_W-1:0] len_cnt,
  input logic [1:0]       unit_cnt,
  input logic             tick
);
  p_len_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_cnt <= LEN_W'(SYM_MAX));

  p_dur_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lamp_o) |-> (unit_cnt == 2'd1 || unit_cnt == 2'd3));

  p_idle_empty_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE) |-> (len_cnt == '0));

  p_busy_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st != ST_IDLE && start_i && !tick) |=> $stable(len_cnt));

  p_start_lamp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE && start_i) |=> lamp_o);

  p_idle_dark_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE && !start_i) |=> !lamp_o);
endmodule

bind morse_tx morse_tx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .lamp_o(lamp_o),
  .st(st), .len_cnt(len_cnt), .unit_cnt(unit_cnt), .tick(tick)
);

// File: tb/sim_morse_tx.sv
module sim_morse_tx;
  localparam int CLK_HZ  = 8;
  localparam int TICK_HZ = 2;
  localparam int U = CLK_HZ / TICK_HZ;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] letter_i = 3'd0;
  logic       lamp_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  string pat [8] = '{".-", "-...", "-.-.", "-..", ".", "..-.", "--.", "...."};

  morse_tx #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .letter_i(letter_i), .lamp_o(lamp_o)
  );

  always #4 clk_i = ~clk_i;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Send one letter and compare every cycle against the model.
  // poke_at >= 0: at that sample index, raise start_i for one cycle with another letter.
  // chg_at  >= 0: at that sample index, change letter_i.
  task automatic send_cmp(input int l, input int poke_at, input int chg_at,
                          input int tail, input string req);
    bit exp_w[$];
    int errs = 0;
    int first = -1;
    int fa = 0;
    int fe = 0;
    string p = pat[l];
    for (int s = 0; s < p.len(); s++) begin
      int on = (p[s] == "-") ? 3 * U : U;
      for (int k = 0; k < on; k++) exp_w.push_back(1'b1);
      if (s != p.len() - 1) for (int k = 0; k < U; k++) exp_w.push_back(1'b0);
    end
    for (int k = 0; k < tail; k++) exp_w.push_back(1'b0);
    letter_i = 3'(l);
    start_i  = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < exp_w.size(); i++) begin
      if (lamp_o !== exp_w[i]) begin
        errs++;
        if (first < 0) begin
          first = i;
          fa = int'(lamp_o);
          fe = int'(exp_w[i]);
        end
      end
      start_i = (i == poke_at);
      if (i == poke_at) letter_i = 3'(l ^ 3'd7);
      if (i == chg_at)  letter_i = 3'(l ^ 3'd5);
      @(negedge clk_i);
      start_i = 1'b0;
    end
    check(errs == 0, $sformatf("%s letter=%0d first_bad_idx=%0d", req, l, first), fa, fe);
  endtask

  task automatic t_reset();
    rst_ni = 1'b0;
    #1;
    check(lamp_o == 1'b0, "R6 lamp low in reset", int'(lamp_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2 * U) @(negedge clk_i);
    check(lamp_o == 1'b0, "R8 idle lamp low with no start", int'(lamp_o), 0);
  endtask

  task automatic t_letters();
    for (int l = 0; l < 8; l++) send_cmp(l, -1, -1, 2 * U, "R1 R2 R3 R7 waveform");
  endtask

  task automatic t_busy_start();
    // start during the dash of B, and again during a gap of C
    send_cmp(1, 2, -1, 3 * U, "R5 start during dash ignored");
    send_cmp(2, 3 * U + 1, -1, 3 * U, "R5 start during gap ignored");
  endtask

  task automatic t_letter_change();
    send_cmp(5, -1, 1, 2 * U, "R4 selector change mid-letter");
  endtask

  task automatic t_async_reset();
    letter_i = 3'd6;
    start_i  = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (U) @(negedge clk_i);
    check(lamp_o == 1'b1, "R6 lamp on before reset", int'(lamp_o), 1);
    #1 rst_ni = 1'b0;
    #1;
    check(lamp_o == 1'b0, "R6 async reset clears lamp between edges", int'(lamp_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (5 * U) @(negedge clk_i);
    check(lamp_o == 1'b0, "R6 idle after reset release", int'(lamp_o), 0);
    send_cmp(0, -1, -1, U, "R6 full letter after reset");
  endtask

  task automatic t_back_to_back();
    send_cmp(4, -1, -1, 0, "R7 first of back-to-back");
    send_cmp(3, -1, -1, 2 * U, "R7 start in first idle cycle");
  endtask

  initial begin
    @(negedge clk_i);
    t_reset();
    t_letters();
    t_busy_start();
    t_letter_change();
    t_async_reset();
    t_back_to_back();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule